// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

The block gathers interrupt requests from `NSRC` sources and decides which one the CPU should service next. Each source owns a sticky pending flag, an enable bit and a 3-bit priority. All of them sit in a small register bank that is reached through a synchronous word bus. On every clock the block compares the enabled, pending sources. The highest programmed priority wins, and among equal priorities the lowest source index wins. The winner's vector number (index plus 8) and its level are then latched into a status register.

The CPU side of the block holds a 4-bit current priority level. An interrupt request goes to the CPU when the latched level is strictly above that level. When the CPU acknowledges, the block saves the current level on a small stack and loads the winner's level. A return restores the saved level, so handlers can nest. A control bit turns nesting off: while any handler is running, the active level is treated as 7.

Register words (address : content): 0 : control, bit 0 = nesting off. 1 : CPU level, bits [3:0]. 2 : status, vector number in [6:0], level in [11:8]. From 4 : pending flags, then enables (16 sources per word, source i at bit i mod 16 of word i/16). After those : priorities, 4 sources per word, source i in bits [4*(i mod 4)+2 : 4*(i mod 4)]. With the default of 32 sources this gives flags at 4–5, enables at 6–7 and priorities at 8–15. Unused bits read 0.

Top module: `irq_vec_ctrl`

## Requirements
- R1: A high `src_req[i]` sampled on a clock edge sets flag i, and the flag stays set until software clears it. A set in the same cycle as a clear write leaves the flag set.
- R2: Writing a flag word clears each flag whose data bit is 1 and leaves flags under 0 bits untouched.
- R3: A source whose enable bit is 0 still sets its flag but never wins arbitration.
- R4: Priority fields are read and written at the layout above, and a source at priority 0 never wins.
- R5: The highest priority among enabled pending sources wins, and equal priorities go to the lowest index.
- R6: One cycle after the flags change, the status register holds vector number = winner index + 8 and level = winner priority. It holds 0 in both fields when no source qualifies. The same values appear on `vec_num` and `vec_lvl`.
- R7: `cpu_irq` is high exactly when the latched level exceeds the active CPU level.
- R8: A write to word 1 loads bits [2:0] of the CPU level. Bit 3 cannot be written by software.
- R9: An acknowledge while `cpu_irq` is high pushes the CPU level and loads the latched level. A return pops the saved level. A return with an empty stack, or an acknowledge with `cpu_irq` low, changes nothing.
- R10: While control bit 0 is set and at least one handler is active, the active level counts as 7 and `cpu_irq` stays low.
- R11: After reset every flag, enable, priority, the status, the CPU level and the control bit read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_req | input | NSRC | Interrupt request lines, sampled every edge |
| reg_addr | input | AW | Register word address |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for `reg_addr`, combinational |
| cpu_ack | input | 1 | CPU accepts the pending interrupt |
| cpu_ret | input | 1 | CPU returns from a handler |
| cpu_irq | output | 1 | Interrupt request to the CPU |
| cpu_level | output | 4 | Current CPU priority level |
| vec_num | output | 7 | Latched vector number |
| vec_lvl | output | 4 | Latched priority level |

## Verification
The bench drives several input patterns and compares every output against a behavioural model on every cycle. Two sources raised together at equal priority show whether ties go to natural order. A disabled source and a priority-0 source show that the flag is stored but never arbitrated. Writes to the CPU level with bit 3 set, and a W1C write that lands in the same cycle as a new request, separate the read-only and sticky rules from plain register behaviour. An acknowledge/return sequence, with nesting on and then off, tells stack restoration apart from the nesting-disable override. A return with an empty stack is included to confirm it changes nothing.

// File: rtl/irq_vec_ctrl.sv
module irq_vec_ctrl #(
  parameter int NSRC = 32,
  parameter int NEST = 8,
  parameter int AW   = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_req,
  input  logic [AW-1:0]   reg_addr,
  input  logic            reg_wr,
  input  logic [15:0]     reg_wdata,
  output logic [15:0]     reg_rdata,
  input  logic            cpu_ack,
  input  logic            cpu_ret,
  output logic            cpu_irq,
  output logic [3:0]      cpu_level,
  output logic [6:0]      vec_num,
  output logic [3:0]      vec_lvl
);
  localparam int DW     = 16;
  localparam int PPW    = DW / 4;
  localparam int NFW    = (NSRC + DW - 1) / DW;
  localparam int NPW    = (NSRC + PPW - 1) / PPW;
  localparam int CTRL_A = 0;
  localparam int LVL_A  = 1;
  localparam int STAT_A = 2;
  localparam int FLAG_A = 4;
  localparam int EN_A   = FLAG_A + NFW;
  localparam int PRI_A  = EN_A + NFW;
  localparam int DEPW   = $clog2(NEST + 1);

  logic [NSRC-1:0] flag, flag_d, en, en_d, clr;
  logic [2:0]      pri   [NSRC];
  logic [2:0]      pri_d [NSRC];
  logic            nest_off;
  logic [3:0]      cpu_lvl;
  logic [3:0]      stk [NEST];
  logic [DEPW-1:0] depth;
  logic [3:0]      best_l, eff_lvl;
  logic [6:0]      best_i;
  logic            ack_ok, ret_ok, lvl_wr;
  int              addr;

  assign addr   = int'(reg_addr);
  assign lvl_wr = reg_wr && addr == LVL_A;

  always_comb begin
    clr   = '0;
    en_d  = en;
    pri_d = pri;
    for (int i = 0; i < NSRC; i++) begin
      if (reg_wr && addr == FLAG_A + i / DW) clr[i]  = reg_wdata[i % DW];
      if (reg_wr && addr == EN_A + i / DW)   en_d[i] = reg_wdata[i % DW];
      if (reg_wr && addr == PRI_A + i / PPW) pri_d[i] = reg_wdata[4*(i%PPW) +: 3];
    end
    flag_d = (flag & ~clr) | src_req;
  end

  always_comb begin
    best_l = '0;
    best_i = '0;
    for (int i = 0; i < NSRC; i++)
      if (flag[i] && en[i] && {1'b0, pri[i]} > best_l) begin
        best_l = {1'b0, pri[i]};
        best_i = 7'(i);
      end
  end

  assign eff_lvl   = (nest_off && depth != '0) ? 4'd7 : cpu_lvl;
  assign cpu_irq   = vec_lvl > eff_lvl;
  assign ack_ok    = cpu_ack && cpu_irq && int'(depth) < NEST;
  assign ret_ok    = !ack_ok && cpu_ret && depth != '0;
  assign cpu_level = cpu_lvl;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag     <= '0;
      en       <= '0;
      nest_off <= 1'b0;
      vec_num  <= '0;
      vec_lvl  <= '0;
      for (int i = 0; i < NSRC; i++) pri[i] <= '0;
    end else begin
      flag <= flag_d;
      en   <= en_d;
      pri  <= pri_d;
      if (reg_wr && addr == CTRL_A) nest_off <= reg_wdata[0];
      vec_lvl <= best_l;
      vec_num <= (best_l != '0) ? best_i + 7'd8 : 7'd0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cpu_lvl <= '0;
      depth   <= '0;
      for (int i = 0; i < NEST; i++) stk[i] <= '0;
    end else if (ack_ok) begin
      stk[int'(depth)] <= cpu_lvl;
      cpu_lvl          <= vec_lvl;
      depth            <= depth + 1'b1;
    end else if (ret_ok) begin
      cpu_lvl <= stk[int'(depth) - 1];
      depth   <= depth - 1'b1;
    end else if (lvl_wr) begin
      cpu_lvl[2:0] <= reg_wdata[2:0];
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (addr == CTRL_A) reg_rdata[0] = nest_off;
    if (addr == LVL_A)  reg_rdata[3:0] = cpu_lvl;
    if (addr == STAT_A) reg_rdata = {4'd0, vec_lvl, 1'b0, vec_num};
    for (int i = 0; i < NSRC; i++) begin
      if (addr == FLAG_A + i / DW) reg_rdata[i % DW] = flag[i];
      if (addr == EN_A + i / DW)   reg_rdata[i % DW] = en[i];
      if (addr == PRI_A + i / PPW) reg_rdata[4*(i%PPW) +: 3] = pri[i];
    end
  end
endmodule

module irq_vec_ctrl_chk #(
  parameter int NSRC = 32,
  parameter int NEST = 8,
  parameter int AW   = 6
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       reg_wr,
  input logic [AW-1:0]              reg_addr,
  input logic                       cpu_ack,
  input logic                       cpu_ret,
  input logic                       cpu_irq,
  input logic [3:0]                 cpu_level,
  input logic [6:0]                 vec_num,
  input logic [3:0]                 vec_lvl,
  input logic [NSRC-1:0]            flag,
  input logic                       nest_off,
  input logic [$clog2(NEST+1)-1:0]  depth
);
  // R1
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_wr |=> (flag & $past(flag)) == $past(flag));
  // R6
  vec_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_lvl == 4'd0) ? (vec_num == 7'd0) : (int'(vec_num) >= 8 && int'(vec_num) < NSRC + 8));
  // R7
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_irq |-> vec_lvl > cpu_level);
  // R8
  lvl_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && int'(reg_addr) == 1 && !cpu_ack && !cpu_ret) |=> cpu_level[3] == $past(cpu_level[3]));
  // R9
  ack_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_ack && cpu_irq && int'(depth) < NEST) |=> cpu_level == $past(vec_lvl));
  // R10
  nest_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (nest_off && depth != '0) |-> !cpu_irq);
endmodule

bind irq_vec_ctrl irq_vec_ctrl_chk #(.NSRC(NSRC), .NEST(NEST), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .cpu_ack(cpu_ack), .cpu_ret(cpu_ret), .cpu_irq(cpu_irq),
  .cpu_level(cpu_level), .vec_num(vec_num), .vec_lvl(vec_lvl),
  .flag(flag), .nest_off(nest_off), .depth(depth)
);

// File: tb/irq_vec_ctrl_test.sv
module irq_vec_ctrl_test;
  localparam int PERIOD = 10;
  localparam int NSRC = 32;
  localparam int NEST = 8;
  localparam int AW = 6;

  logic clk = 0, rst_n = 0;
  logic [NSRC-1:0] src_req = '0;
  logic [AW-1:0] reg_addr = '0;
  logic reg_wr = 0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic cpu_ack = 0, cpu_ret = 0;
  logic cpu_irq;
  logic [3:0] cpu_level, vec_lvl;
  logic [6:0] vec_num;

  int checks = 0, fails = 0;

  irq_vec_ctrl #(.NSRC(NSRC), .NEST(NEST), .AW(AW)) uut (.*);

  always #(PERIOD/2) clk = ~clk;

  // behavioural reference
  int m_flag[NSRC], m_en[NSRC], m_pri[NSRC];
  int m_nest, m_lvl, m_vnum, m_vlvl;
  int m_stk[$];

  function automatic int m_eff();
    return (m_nest != 0 && m_stk.size() > 0) ? 7 : m_lvl;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (m_flag[i]) begin m_flag[i] = 0; m_en[i] = 0; m_pri[i] = 0; end
      m_nest = 0; m_lvl = 0; m_vnum = 0; m_vlvl = 0; m_stk.delete();
    end else begin
      int irq, bl, bi, a;
      irq = m_vlvl > m_eff();
      bl = 0; bi = -1;
      for (int i = NSRC - 1; i >= 0; i--)
        if (m_flag[i] != 0 && m_en[i] != 0 && m_pri[i] >= bl && m_pri[i] > 0) begin bl = m_pri[i]; bi = i; end
      a = int'(reg_addr);
      if (cpu_ack && irq && m_stk.size() < NEST) begin
        m_stk.push_back(m_lvl); m_lvl = m_vlvl;
      end else if (cpu_ret && m_stk.size() > 0) begin
        m_lvl = m_stk.pop_back();
      end else if (reg_wr && a == 1) begin
        m_lvl = (m_lvl & 8) | (reg_wdata & 7);
      end
      if (reg_wr && a == 0) m_nest = reg_wdata[0];
      for (int i = 0; i < NSRC; i++) begin
        if (reg_wr && a == 4 + i/16 && reg_wdata[i%16]) m_flag[i] = 0;
        if (reg_wr && a == 6 + i/16) m_en[i] = reg_wdata[i%16];
        if (reg_wr && a == 8 + i/4) m_pri[i] = (reg_wdata >> (4*(i%4))) & 7;
        if (src_req[i]) m_flag[i] = 1;
      end
      m_vlvl = bl; m_vnum = (bl > 0) ? bi + 8 : 0;
    end
  end

  always @(negedge clk) if (rst_n) begin
    checks++;
    if (int'(vec_num) != m_vnum || int'(vec_lvl) != m_vlvl || int'(cpu_level) != m_lvl ||
        int'(cpu_irq) != int'(m_vlvl > m_eff())) begin
      fails++;
      $display("FAIL R5 R6 R7 R9: got vec=%0d lvl=%0d cpu=%0d irq=%0d exp vec=%0d lvl=%0d cpu=%0d irq=%0d",
        vec_num, vec_lvl, cpu_level, cpu_irq, m_vnum, m_vlvl, m_lvl, m_vlvl > m_eff());
    end
  end

  task automatic tick(int n); repeat (n) @(negedge clk); endtask
  task automatic wr(int a, int d);
    @(negedge clk); reg_addr = AW'(a); reg_wdata = 16'(d); reg_wr = 1;
    @(negedge clk); reg_wr = 0;
  endtask
  task automatic rd(int a, int exp, string tag);
    @(negedge clk); reg_addr = AW'(a); #1;
    checks++;
    if (int'(reg_rdata) != exp) begin
      fails++; $display("FAIL %s: addr %0d got %h exp %h", tag, a, reg_rdata, exp[15:0]);
    end
  endtask
  task automatic pulse(int s);
    @(negedge clk); src_req[s] = 1; @(negedge clk); src_req[s] = 0;
  endtask
  task automatic ack(); @(negedge clk); cpu_ack = 1; @(negedge clk); cpu_ack = 0; endtask
  task automatic ret(); @(negedge clk); cpu_ret = 1; @(negedge clk); cpu_ret = 0; endtask
  task automatic chk_irq(int exp, string tag);
    @(negedge clk); #1; checks++;
    if (int'(cpu_irq) != exp) begin fails++; $display("FAIL %s: irq got %0d exp %0d", tag, cpu_irq, exp); end
  endtask

  initial begin : watchdog
    #(PERIOD * 20000);
    fails++; $display("FAIL watchdog: got timeout exp completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    tick(3); rst_n = 1; tick(1);
    // R11 reset state
    rd(0, 0, "R11"); rd(1, 0, "R11"); rd(2, 0, "R11"); rd(4, 0, "R11"); rd(8, 0, "R11");
    // R4 layout
    wr(8, 16'h5002); wr(9, 16'h0050); wr(10, 0); wr(12, 16'h0070);
    rd(8, 16'h5002, "R4"); rd(12, 16'h0070, "R4");
    wr(6, 16'h0229);
    rd(6, 16'h0229, "R3");
    // R5 tie at level 5: sources 3 and 5
    @(negedge clk); src_req[3] = 1; src_req[5] = 1; @(negedge clk); src_req = '0;
    tick(2);
    rd(2, 16'h050B, "R5 R6");
    chk_irq(1, "R7");
    // R3 disabled source
    pulse(17); tick(2);
    rd(5, 16'h0002, "R3"); rd(2, 16'h050B, "R3");
    // R8 level write
    wr(1, 16'h000F); rd(1, 16'h0007, "R8"); chk_irq(0, "R7");
    wr(1, 4); chk_irq(1, "R7");
    // R9 ack
    ack(); rd(1, 5, "R9"); chk_irq(0, "R7");
    // R2 W1C
    rd(4, 16'h0028, "R1"); wr(4, 0); rd(4, 16'h0028, "R2");
    wr(4, 16'h0008); rd(4, 16'h0020, "R2"); tick(1);
    rd(2, 16'h050D, "R6");
    // nesting to 7
    wr(7, 16'h0002); tick(1); rd(2, 16'h0719, "R6"); chk_irq(1, "R7");
    ack(); rd(1, 7, "R9");
    ret(); rd(1, 5, "R9"); ret(); rd(1, 4, "R9");
    ret(); rd(1, 4, "R9");
    // R10 nesting disable
    wr(0, 1); rd(0, 1, "R10");
    wr(5, 16'h0002); tick(1); rd(2, 16'h050D, "R6");
    chk_irq(1, "R10");
    ack(); rd(1, 5, "R9");
    wr(8, 16'h5006); pulse(0); tick(2);
    rd(2, 16'h0608, "R5"); chk_irq(0, "R10");
    wr(0, 0); chk_irq(1, "R10");
    ret();
    // R4 priority zero never wins
    wr(4, 16'hFFFF); wr(5, 16'hFFFF); tick(1);
    pulse(9); tick(2);
    rd(4, 16'h0200, "R4"); rd(2, 0, "R4");
    // R1 set beats clear in the same cycle
    @(negedge clk); reg_addr = AW'(4); reg_wdata = 16'h0001; reg_wr = 1; src_req[0] = 1;
    @(negedge clk); reg_wr = 0; src_req[0] = 0;
    rd(4, 16'h0201, "R1");
    tick(3);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule